// File: doc/BRIEF.md
# Two-Level Pending Interrupt Status Register

This block holds the status byte that a host reads after an interrupt, together with the interrupt line. It has two levels of storage. The primary register is what the host sees. The secondary register holds one pending status set. This set arrives when the primary still holds status the host has not read, or when a read is in progress. When a read completes, any pending set moves into the primary and the interrupt comes back one cycle later. A host that services the line in a loop therefore never loses the most recent event.

Status events come from two sources. The first is a call-received strobe that carries its status bits. The second is a change of the out-of-range flag. An internal flag tracks reception quality: it is set when an out-of-range mode is entered and cleared when preamble or a valid sync word is seen. This flag reaches the status byte only at the moment the receiver is disabled, and only a real change of the reported value counts as an event. A single-cycle read strobe stands in for the host bus transfer. The byte on the output is valid during the strobe cycle.

Top module: `pend_stat_reg`

## Requirements
- R1: When an event arrives while the interrupt is asserted and no read is in progress, the status output stays unchanged and the event's status is held as pending.
- R2: An event that arrives in the read strobe cycle, or in the cycle after it, is held as pending. It appears on the status output when the read completes.
- R3: When a read completes with status pending, the primary takes the pending status and the pending storage is emptied. A further read then finds nothing pending.
- R4: In the cycle after the read strobe the interrupt is low. If status was pending, the interrupt is high again in the next cycle.
- R5: If several events are pending before a read, only the most recent one is delivered.
- R6: The internal out-of-range flag is set by an out-of-range entry pulse and cleared by a preamble/sync pulse. When both pulses come in the same cycle, the entry wins.
- R7: Status bit 5 shows the out-of-range value reported at the most recent falling edge of receiver-enable. It changes at no other time. A falling edge that changes the reported value raises an interrupt with that value in bit 5 and the other bits zero. A falling edge with no change raises nothing.
- R8: A read with nothing pending drops the interrupt, and the interrupt stays low.
- R9: With the interrupt low and no read in progress, a call event loads the primary and raises the interrupt on the next cycle. Bit 5 of the call's status input is ignored and replaced by the reported out-of-range value.
- R10: An all-zero status can be queued. After the read, it is delivered with the interrupt asserted.
- R11: After reset the status output is zero and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_evt | input | 1 | Call-received strobe, one cycle |
| call_stat | input | STAT_W | Status bits of the received call |
| rx_en | input | 1 | Receiver enable level |
| oor_enter | input | 1 | Out-of-range mode entered, one cycle |
| oor_clear | input | 1 | Preamble or valid sync seen, one cycle |
| rd_stb | input | 1 | Host status read strobe, one cycle |
| stat_q | output | STAT_W | Primary status byte |
| irq | output | 1 | Interrupt, active high |

## Verification
On every cycle, the assertions check the read handshake and the queuing: the interrupt drop after a strobe, the reload from pending storage with its re-raise, the emptying of that storage, and the empty-read case. They also check that events are captured while unread status is held, and that the reported out-of-range value stays stable away from a receiver-enable falling edge. The bench scenarios cover what depends on value history. These are last-event-wins over several pending calls, delivery of an all-zero status, the replacement of bit 5 in call status, entry-over-clear priority on the internal flag, and the absence of an interrupt when a falling edge reports no change.

// File: rtl/pend_stat_reg.sv
module pend_stat_reg #(
  parameter int STAT_W  = 8,
  parameter int OOR_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_evt,
  input  logic [STAT_W-1:0] call_stat,
  input  logic              rx_en,
  input  logic              oor_enter,
  input  logic              oor_clear,
  input  logic              rd_stb,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq
);

  logic [STAT_W-1:0] pri, sec, evt_byte;
  logic sec_v, irq_r, rd_busy, rx_en_d, oor_live, oor_rep;

  wire rx_fall = rx_en_d & ~rx_en;
  wire oor_nxt = rx_fall ? oor_live : oor_rep;
  wire oor_evt = rx_fall & (oor_live != oor_rep);
  wire evt     = call_evt | oor_evt;

  always_comb begin
    evt_byte          = call_evt ? call_stat : '0;
    evt_byte[OOR_BIT] = oor_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri      <= '0;
      sec      <= '0;
      sec_v    <= 1'b0;
      irq_r    <= 1'b0;
      rd_busy  <= 1'b0;
      rx_en_d  <= 1'b0;
      oor_live <= 1'b0;
      oor_rep  <= 1'b0;
    end else begin
      rx_en_d <= rx_en;
      rd_busy <= rd_stb;
      oor_rep <= oor_nxt;
      if (oor_enter)      oor_live <= 1'b1;
      else if (oor_clear) oor_live <= 1'b0;

      if (rd_stb) begin
        irq_r <= 1'b0;
        if (evt) begin
          sec   <= evt_byte;
          sec_v <= 1'b1;
        end
      end else if (rd_busy) begin
        if (sec_v) begin
          pri   <= sec;
          irq_r <= 1'b1;
          if (evt) sec <= evt_byte;
          else begin
            sec   <= '0;
            sec_v <= 1'b0;
          end
        end else if (evt) begin
          pri   <= evt_byte;
          irq_r <= 1'b1;
        end
      end else if (evt) begin
        if (irq_r) begin
          sec   <= evt_byte;
          sec_v <= 1'b1;
        end else begin
          pri   <= evt_byte;
          irq_r <= 1'b1;
        end
      end
    end
  end

  assign stat_q = pri;
  assign irq    = irq_r;

endmodule

module pend_stat_reg_chk #(
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic              call_evt,
  input logic              rx_en,
  input logic [STAT_W-1:0] stat_q,
  input logic              irq,
  input logic [STAT_W-1:0] sec,
  input logic              sec_v,
  input logic              rd_busy,
  input logic              rx_en_d,
  input logic              oor_rep
);

  wire fall = rx_en_d && !rx_en;

  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) rd_stb |=> !irq); // R4
  AST_RELOAD_REIRQ: assert property (@(posedge clk) disable iff (!rst_n) (rd_busy && sec_v) |=> (irq && stat_q == $past(sec))); // R3
  AST_SEC_EMPTIED: assert property (@(posedge clk) disable iff (!rst_n) (rd_busy && sec_v && !call_evt && !fall) |=> !sec_v); // R3
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd_busy && !sec_v && !call_evt && !fall) |=> !irq); // R8
  AST_HOLD_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n) (irq && !rd_stb && !rd_busy) |=> $stable(stat_q)); // R1
  AST_QUEUE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (irq && !rd_stb && !rd_busy && call_evt) |=> sec_v); // R1
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb && call_evt) |=> sec_v); // R2
  AST_OOR_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) !fall |=> $stable(oor_rep)); // R7

endmodule

bind pend_stat_reg pend_stat_reg_chk #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .call_evt(call_evt), .rx_en(rx_en),
  .stat_q(stat_q), .irq(irq), .sec(sec), .sec_v(sec_v), .rd_busy(rd_busy),
  .rx_en_d(rx_en_d), .oor_rep(oor_rep)
);

// File: tb/pend_stat_reg_tb.sv
module pend_stat_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       call_evt = 1'b0;
  logic [7:0] call_stat = '0;
  logic       rx_en = 1'b0;
  logic       oor_enter = 1'b0;
  logic       oor_clear = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] stat_q;
  logic       irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pend_stat_reg u_dut (
    .clk(clk), .rst_n(rst_n), .call_evt(call_evt), .call_stat(call_stat),
    .rx_en(rx_en), .oor_enter(oor_enter), .oor_clear(oor_clear),
    .rd_stb(rd_stb), .stat_q(stat_q), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: irq/stat actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic call(logic [7:0] s);
    call_evt = 1'b1; call_stat = s; tick();
    call_evt = 1'b0; call_stat = '0;
  endtask

  task automatic rd_empty(string req);
    rd_stb = 1'b1; tick(); rd_stb = 1'b0;
    chk(req, {irq, 8'h00}, 9'h000);
    tick();
    chk(req, {irq, 8'h00}, 9'h000);
  endtask

  task automatic t_reset();
    chk("R11", {irq, stat_q}, 9'h000);
  endtask

  task automatic t_idle_call();
    call(8'hA1);
    chk("R9", {irq, stat_q}, 9'h181);
    rd_empty("R8");
    call(8'h83);
    chk("R9", {irq, stat_q}, 9'h183);
  endtask

  task automatic t_queue();
    call(8'h11);
    chk("R1", {irq, stat_q}, 9'h183);
    call(8'h42);
    chk("R1", {irq, stat_q}, 9'h183);
    rd_stb = 1'b1; tick(); rd_stb = 1'b0;
    chk("R4", {irq, stat_q}, 9'h083);
    tick();
    chk("R5", {irq, stat_q}, 9'h142);
    rd_empty("R3");
  endtask

  task automatic t_during_read();
    call(8'h05);
    rd_stb = 1'b1; call_evt = 1'b1; call_stat = 8'h44; tick();
    rd_stb = 1'b0; call_evt = 1'b0; call_stat = '0;
    chk("R2", {1'b0, irq}, 9'h000);
    tick();
    chk("R2", {irq, stat_q}, 9'h144);
    rd_stb = 1'b1; tick(); rd_stb = 1'b0;
    call(8'h09);
    chk("R2", {irq, stat_q}, 9'h109);
    rd_empty("R8");
  endtask

  task automatic t_zero();
    call(8'h12);
    call(8'h00);
    rd_stb = 1'b1; tick(); rd_stb = 1'b0;
    tick();
    chk("R10", {irq, stat_q}, 9'h100);
    rd_empty("R3");
  endtask

  task automatic t_oor();
    rx_en = 1'b1; tick();
    oor_enter = 1'b1; tick(); oor_enter = 1'b0;
    tick();
    chk("R7", {irq, stat_q}, 9'h000);
    rx_en = 1'b0; tick();
    chk("R7", {irq, stat_q}, 9'h120);
    rd_empty("R8");
    rx_en = 1'b1; tick(); rx_en = 1'b0; tick();
    chk("R7", {irq, stat_q}, 9'h020);
    rx_en = 1'b1; tick();
    oor_clear = 1'b1; tick(); oor_clear = 1'b0;
    rx_en = 1'b0; tick();
    chk("R6", {irq, stat_q}, 9'h100);
    rd_empty("R8");
    rx_en = 1'b1; tick();
    oor_enter = 1'b1; oor_clear = 1'b1; tick();
    oor_enter = 1'b0; oor_clear = 1'b0;
    rx_en = 1'b0; tick();
    chk("R6", {irq, stat_q}, 9'h120);
    rd_empty("R8");
    call(8'h01);
    chk("R9", {irq, stat_q}, 9'h121);
    rd_empty("R8");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_idle_call();
    t_queue();
    t_during_read();
    t_zero();
    t_oor();
    finish_run();
  end
endmodule